// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into an asynchronous NRZ serial frame. The frame is a start bit, then the character slots, then one stop bit. The character is either 8 or 9 slots long. When parity is switched on, the parity bit fills the last character slot, which is the slot just before the stop bit. Data bits then fill the slots before it, so one fewer data bit is sent. The data bits can go out lowest first or highest first.

A host presents a character and its format on the load inputs and raises `ld_valid`. The block accepts the character on any clock edge where `busy` is low. It captures the frame at that edge, so the data and format inputs may change afterwards without effect. An external rate generator supplies `bit_tick`, a pulse one clock wide that marks each bit period. The first tick after acceptance starts the start bit. Every later tick moves the line to the next bit. The tick that ends the stop bit also drops `busy`.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `tx_line` is 1 and `busy` is 0. The line is 1 whenever `busy` is 0.
- R2: `ld_valid` high at a clock edge where `busy` is 0 loads the character, and `busy` is 1 after that edge. The line stays 1 until the first `bit_tick` after the load. A tick in the same cycle as the load does not start the frame.
- R3: At the first tick edge after the load the line goes to 0, which is the start bit. The line changes only at tick edges, so every bit lasts exactly one tick period.
- R4: With `cfg_wide`=0 and `cfg_parity`=0, the character is the 8 data bits `ld_data[7:0]`, and `ld_data[8]` is not sent.
- R5: With `cfg_wide`=0 and `cfg_parity`=1, the character is 7 data bits `ld_data[6:0]` followed by the parity bit. `ld_data[8:7]` are not sent.
- R6: With `cfg_wide`=1 and `cfg_parity`=0, the character is 9 data bits `ld_data[8:0]`. The top bit, which can serve as an address mark, is sent like any other data bit.
- R7: With `cfg_wide`=1 and `cfg_parity`=1, the character is 8 data bits `ld_data[7:0]` followed by the parity bit. `ld_data[8]` is not sent.
- R8: With `cfg_msb_first`=0 the data bits go out from bit 0 upward. With `cfg_msb_first`=1 they go out from the highest sent data bit downward. In both orders the parity bit sits in the slot just before the stop bit.
- R9: The parity bit is the XOR of the sent data bits when `cfg_odd`=0 (even parity) and the inverse of that XOR when `cfg_odd`=1 (odd parity).
- R10: The stop bit is 1 and lasts one tick period. At the tick that ends it, `busy` falls and the line stays 1. A new load can be accepted in the first cycle where `busy` is 0.
- R11: `ld_valid` while `busy` is 1 is ignored. A change of data or format inputs during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-clock pulse that marks each bit period |
| ld_valid | input | 1 | Load request for the character on `ld_data` |
| ld_data | input | 9 | Character data; the bits not sent depend on the format |
| cfg_wide | input | 1 | 1 selects a 9-slot character, 0 selects 8 slots |
| cfg_parity | input | 1 | 1 puts a parity bit in the last character slot |
| cfg_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_msb_first | input | 1 | 1 sends the data bits highest first |
| tx_line | output | 1 | Serial output; 1 when idle |
| busy | output | 1 | 1 from acceptance until the stop bit ends |

## Verification
The assertions assume that `bit_tick` is never high on two clock cycles in a row. Bit-duration stability is only meaningful under that assumption. The bench derives its tick from a free-running divide-by-four counter, so the assumption holds at every point of the run. The assertions also assume that `ld_valid` may arrive at any time, busy or not. The stimulus therefore includes a load pulse in the middle of a frame, together with changed data and format. It also includes a load on the same edge as a tick, and a load in the very first idle cycle after a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // widest character (slots between start and stop)
  localparam int CHAR_MAX_W = 9;
  // start + character + stop
  localparam int FRAME_W    = CHAR_MAX_W + 2;
  localparam int CNT_W      = $clog2(FRAME_W + 1);
  localparam int IDX_W      = $clog2(FRAME_W);

  typedef struct packed {
    logic wide;       // 9-slot character
    logic par_en;     // parity in last slot
    logic par_odd;    // odd sense
    logic msb_first;  // data order
  } tx_cfg_t;

  function automatic int char_slots(input tx_cfg_t cfg);
    return cfg.wide ? CHAR_MAX_W : CHAR_MAX_W - 1;
  endfunction

  function automatic int data_count(input tx_cfg_t cfg);
    return char_slots(cfg) - (cfg.par_en ? 1 : 0);
  endfunction

  function automatic logic [CNT_W-1:0] frame_bits(input tx_cfg_t cfg);
    return CNT_W'(char_slots(cfg) + 2);
  endfunction

  // frame word: bit 0 leaves first; unused upper bits read as idle 1
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [CHAR_MAX_W-1:0] data,
    input tx_cfg_t               cfg
  );
    logic [CHAR_MAX_W-1:0] slots;
    logic [FRAME_W-1:0]    word;
    logic                  par;
    int                    clen;
    int                    dlen;
    clen  = char_slots(cfg);
    dlen  = data_count(cfg);
    slots = '0;
    par   = cfg.par_odd;
    for (int i = 0; i < CHAR_MAX_W; i++) begin
      if (i < dlen) begin
        par = par ^ data[IDX_W'(i)];
        if (cfg.msb_first) slots[IDX_W'(i)] = data[IDX_W'(dlen - 1 - i)];
        else               slots[IDX_W'(i)] = data[IDX_W'(i)];
      end
    end
    if (cfg.par_en) slots[IDX_W'(dlen)] = par;
    word    = '1;
    word[0] = 1'b0;
    for (int i = 0; i < CHAR_MAX_W; i++) begin
      if (i < clen) word[IDX_W'(i + 1)] = slots[IDX_W'(i)];
    end
    return word;
  endfunction

endpackage

// File: rtl/uftx_framer.sv
module uftx_framer
  import uart_tx_pkg::*;
(
  input  logic [CHAR_MAX_W-1:0] char_in,
  input  tx_cfg_t               cfg_in,
  output logic [FRAME_W-1:0]    frame_word,
  output logic [CNT_W-1:0]      frame_len
);

  always_comb begin
    frame_word = build_frame(char_in, cfg_in);
    frame_len  = frame_bits(cfg_in);
  end

  // start slot must be low and length must fit the word
  always_comb begin
    start_low_chk: assert (frame_word[0] == 1'b0 || $isunknown(char_in));
    len_fit_chk:   assert (frame_len <= CNT_W'(FRAME_W) || $isunknown(cfg_in));
  end

endmodule

// File: rtl/uftx_sequencer.sv
module uftx_sequencer
  import uart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               req,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic [CNT_W-1:0]   frame_len,
  output logic               line,
  output logic               busy
);

  logic               busy_q;
  logic               line_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   left_q;
  logic [CNT_W-1:0]   len_q;

  // named events
  logic accept_w;
  logic shift_w;
  logic done_w;
  logic first_bit_w;

  assign accept_w    = req && !busy_q;
  assign shift_w     = busy_q && tick && (left_q != '0);
  assign done_w      = busy_q && tick && (left_q == '0);
  assign first_bit_w = shift_w && (left_q == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      line_q  <= 1'b1;
      shreg_q <= '1;
      left_q  <= '0;
      len_q   <= '0;
    end else if (accept_w) begin
      busy_q  <= 1'b1;
      shreg_q <= frame_word;
      left_q  <= frame_len;
      len_q   <= frame_len;
    end else if (shift_w) begin
      line_q  <= shreg_q[0];
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      left_q  <= left_q - CNT_W'(1);
    end else if (done_w) begin
      busy_q  <= 1'b0;
      line_q  <= 1'b1;
    end
  end

  assign line = line_q;
  assign busy = busy_q;

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line_q);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_bit_w |=> !line_q);

  // R3
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(line_q));

  // R3
  left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q <= len_q));

  // R10
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && left_q == '0) |-> line_q);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> (!busy_q && line_q));

  // R11
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req && !tick) |=> ($stable(shreg_q) && $stable(left_q)));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_tick,
  input  logic                  ld_valid,
  input  logic [CHAR_MAX_W-1:0] ld_data,
  input  logic                  cfg_wide,
  input  logic                  cfg_parity,
  input  logic                  cfg_odd,
  input  logic                  cfg_msb_first,
  output logic                  tx_line,
  output logic                  busy
);

  tx_cfg_t            cfg_w;
  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   len_w;

  assign cfg_w = '{wide: cfg_wide, par_en: cfg_parity,
                   par_odd: cfg_odd, msb_first: cfg_msb_first};

  uftx_framer u_framer (
    .char_in    (ld_data),
    .cfg_in     (cfg_w),
    .frame_word (frame_w),
    .frame_len  (len_w)
  );

  uftx_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bit_tick),
    .req        (ld_valid),
    .frame_word (frame_w),
    .frame_len  (len_w),
    .line       (tx_line),
    .busy       (busy)
  );

endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0;
  logic [8:0] ld_data = '0;
  logic       cfg_wide = 1'b0;
  logic       cfg_parity = 1'b0;
  logic       cfg_odd = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic       tx_line;
  logic       busy;
  logic [1:0] tcnt;
  logic       bit_tick;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 2'd1;
  end
  assign bit_tick = (tcnt == 2'd3);

  uart_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ld_valid(ld_valid),
    .ld_data(ld_data), .cfg_wide(cfg_wide), .cfg_parity(cfg_parity),
    .cfg_odd(cfg_odd), .cfg_msb_first(cfg_msb_first),
    .tx_line(tx_line), .busy(busy));

  // {frame length, data, wide, parity, odd, msb_first}
  localparam logic [16:0] VEC [NVEC] = '{
    {4'd10, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd10, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd10, 9'h1C3, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd10, 9'h0C3, 1'b0, 1'b1, 1'b1, 1'b1},
    {4'd11, 9'h12D, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd11, 9'h12D, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd11, 9'h0F1, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'd11, 9'h1F1, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'd10, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd11, 9'h1FF, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // expected bit sequence, built from the requirements
  task automatic expect_frame(input logic [8:0] d, input logic [3:0] c,
                              output logic [10:0] bits, output int n);
    int slots;
    int nd;
    int ones;
    int p;
    slots = c[3] ? 9 : 8;
    nd    = slots - (c[2] ? 1 : 0);
    bits  = '1;
    p     = 0;
    bits[p++] = 1'b0;
    ones  = 0;
    if (c[0]) begin
      for (int j = nd - 1; j >= 0; j--) bits[p++] = d[j];
    end else begin
      for (int j = 0; j < nd; j++) bits[p++] = d[j];
    end
    for (int j = 0; j < nd; j++) ones += d[j];
    if (c[2]) bits[p++] = c[1] ? ~ones[0] : ones[0];
    bits[p++] = 1'b1;
    n = p;
  endtask

  // call at a negedge; returns at the negedge where busy has fallen
  task automatic run_frame(input logic [8:0] d, input logic [3:0] c,
                           input bit poke, input int exp_len);
    logic [10:0] bits;
    int          n;
    logic        prev;
    string       mode;
    bit          poked;
    expect_frame(d, c, bits, n);
    mode = c[3] ? (c[2] ? "R7" : "R6") : (c[2] ? "R5" : "R4");
    mode = {mode, " R8", c[2] ? " R9" : ""};
    chk(n == exp_len, {mode, " length"}, n, exp_len);
    ld_data = d;
    {cfg_wide, cfg_parity, cfg_odd, cfg_msb_first} = c;
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after load", busy, 1);
    prev  = 1'b1;
    poked = 0;
    for (int k = 0; k < n; k++) begin
      while (!bit_tick) begin
        chk(tx_line == prev, k == 0 ? "R2 idle before start" : "R3 bit hold",
            tx_line, prev);
        if (poke && k == 3 && !poked) begin
          // R11: load attempt and format change mid-frame
          ld_data  = ~d;
          {cfg_wide, cfg_parity, cfg_odd, cfg_msb_first} = ~c;
          ld_valid = 1'b1;
          poked    = 1;
        end
        @(negedge clk);
        ld_valid = 1'b0;
      end
      @(negedge clk);
      chk(tx_line == bits[k],
          $sformatf("%s%s slot %0d", mode, poke ? " R11" : "", k),
          tx_line, bits[k]);
      prev = bits[k];
    end
    while (!bit_tick) begin
      chk(tx_line == 1'b1 && busy == 1'b1, "R10 stop hold", {busy, tx_line}, 3);
      @(negedge clk);
    end
    @(negedge clk);
    chk(busy == 1'b0 && tx_line == 1'b1, "R10 release", {busy, tx_line}, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tx_line == 1'b1, "R1 line in reset", tx_line, 1);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(tx_line == 1'b1 && busy == 1'b0, "R1 idle after reset", {busy, tx_line}, 1);

    // table walk; frames run back to back (R10 first idle cycle load)
    for (int v = 0; v < NVEC; v++) begin
      run_frame(VEC[v][12:4], VEC[v][3:0], 1'b0, int'(VEC[v][16:13]));
    end

    // R11: load and format change during a frame
    run_frame(9'h0B6, 4'b0001, 1'b1, 10);
    run_frame(9'h15A, 4'b1110, 1'b1, 11);

    // R2: load on the same edge as a tick
    while (!bit_tick) @(negedge clk);
    run_frame(9'h03C, 4'b0100, 1'b0, 10);

    // R1: idle line after a gap
    repeat (9) @(negedge clk);
    chk(tx_line == 1'b1 && busy == 1'b0, "R1 idle gap", {busy, tx_line}, 1);

    finish_run();
  end

endmodule